// File: doc/BRIEF.md
# Overcurrent Alarm Filter and Counter

This block sits between an external overcurrent alarm pin and the thermal throttle logic of a chip. It brings the asynchronous alarm into the clock domain, corrects its polarity, and treats each inactive-to-active transition as one alarm event. Events are counted against a programmable threshold. An interrupt flag is raised when the threshold is reached, and the count restarts from zero. A quiet-time filter also returns the count to zero when no new event arrives for a programmed number of cycles.

Independently of the counting path, the block drives a throttle request. The request is high while the alarm is active and stays high for a programmed number of microseconds after the alarm goes away. The microsecond time base comes from a prescaler with a programmable cycles-per-microsecond count. Arbitration between throttle sources and the actual clock skipping happen outside this block. All configuration inputs are expected to be static while the block is out of reset.

Top module: `oc_alarm_guard`

## Requirements
- R1: After reset, `irqFlag` and `throttleReq` are both 0.
- R2: With `cfgActiveLow`=1 a low level on `alarmIn` is the active alarm. With `cfgActiveLow`=0 a high level is the active alarm.
- R3: With counting enabled and `cfgThreshold`=N (N>=1), `irqFlag` rises on the N-th event. The event count then restarts from zero, so the next interrupt needs N further events.
- R4: With counting enabled and `cfgThreshold`=0, every event raises `irqFlag`.
- R5: With `cfgThreshEn`=0, no number of events raises `irqFlag`.
- R6: When `cfgFilterCycles`=F is nonzero and F clock cycles pass after an event without a further event, the event count returns to zero.
- R7: When `cfgFilterCycles`=0, the quiet-time clear is disabled and events accumulate however far apart they are.
- R8: `throttleReq` is 1 no later than three clock edges after `alarmIn` becomes active, and it stays 1 while the alarm stays active.
- R9: After the alarm deasserts, `throttleReq` stays 1 for about `cfgHoldUs` x `cfgCyclesPerUs` cycles and then falls to 0. A `cfgCyclesPerUs` of 0 is treated as 1.
- R10: With `cfgHoldUs`=0, `throttleReq` falls within four clock edges of the alarm deasserting.
- R11: `irqFlag` is sticky. It stays 1 until a one-cycle `irqClear` pulse clears it. A new interrupt in the same cycle takes priority over the clear.
- R12: An alarm held active for many cycles counts as one event only. Only the inactive-to-active transition is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| alarmIn | input | 1 | Asynchronous external overcurrent alarm |
| cfgActiveLow | input | 1 | 1: alarm is asserted low; 0: asserted high |
| cfgThreshEn | input | 1 | Enables the interrupt from the event count |
| cfgThreshold | input | CNT_W | Event count that raises the interrupt (0: every event) |
| cfgFilterCycles | input | FILT_W | Quiet cycles after which the count clears (0: never) |
| cfgHoldUs | input | HOLD_W | Throttle hold time after deassertion, in microseconds |
| cfgCyclesPerUs | input | PRE_W | Clock cycles per microsecond tick |
| irqClear | input | 1 | One-cycle pulse that clears the interrupt flag |
| irqFlag | output | 1 | Sticky overcurrent interrupt flag |
| throttleReq | output | 1 | Throttle request, held after the alarm deasserts |

## Verification
The event count is not visible at the ports, so a wrong count shows up only as an interrupt that comes early, late or not at all. The tests therefore walk through the count with interrupt clears in between, so that an off-by-one or a missed restart changes which pulse raises the flag. A quiet-time timer that runs too long or too short shows up on the third pulse of a widely or narrowly spaced train. A wrong hold-timer or prescaler state shows up as `throttleReq` falling early or lingering, which is checked both in the middle of the hold window and well after it ends.

// File: rtl/oc_alarm_pkg.sv
package oc_alarm_pkg;

  // Status decoded by the datapath and handed to the control.
  typedef struct packed {
    logic level;      // synchronized, polarity-corrected alarm
    logic prevLevel;  // level one cycle earlier
    logic rise;       // inactive -> active: one alarm event
    logic fall;       // active -> inactive
    logic quietDone;  // filter window elapsed without an event
    logic holdBusy;   // hold timer still running
  } ocStatus_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic cntInc;
    logic cntClear;
    logic quietRestart;
    logic holdLoad;
  } ocStrobe_t;

endpackage

// File: rtl/oc_alarm_datapath.sv
module oc_alarm_datapath
  import oc_alarm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FILT_W = 24,
  parameter int HOLD_W = 16,
  parameter int PRE_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alarmIn,
  input  logic              cfgActiveLow,
  input  logic [FILT_W-1:0] cfgFilterCycles,
  input  logic [HOLD_W-1:0] cfgHoldUs,
  input  logic [PRE_W-1:0]  cfgCyclesPerUs,
  input  ocStrobe_t         strobe,
  output ocStatus_t         stat,
  output logic [CNT_W-1:0]  evtCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Synchronizer. The polarity fix sits in front because the config is static.
  logic [SYNC_STAGES-1:0] syncReg;
  logic level;
  logic prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '0;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], alarmIn ^ cfgActiveLow};
    end
  end

  assign level = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= level;
  end

  // Event counter, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt <= '0;
    end else if (strobe.cntClear) begin
      evtCnt <= '0;
    end else if (strobe.cntInc && evtCnt != CNT_MAX) begin
      evtCnt <= evtCnt + 1'b1;
    end
  end

  // Quiet-time filter.
  logic [FILT_W-1:0] quietCnt;
  logic              quietArmed;
  logic              quietDone;

  assign quietDone = quietArmed && (cfgFilterCycles != '0) &&
                     (quietCnt == cfgFilterCycles - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt   <= '0;
      quietArmed <= 1'b0;
    end else if (strobe.quietRestart) begin
      quietCnt   <= '0;
      quietArmed <= 1'b1;
    end else if (quietArmed) begin
      if (quietDone) begin
        quietArmed <= 1'b0;
        quietCnt   <= '0;
      end else begin
        quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  // Microsecond prescaler and hold timer.
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLast;
  logic [HOLD_W-1:0] holdCnt;

  assign preLast = (cfgCyclesPerUs == '0) ? '0 : cfgCyclesPerUs - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      holdCnt <= '0;
    end else if (strobe.holdLoad) begin
      preCnt  <= '0;
      holdCnt <= cfgHoldUs;
    end else if (holdCnt != '0) begin
      if (preCnt == preLast) begin
        preCnt  <= '0;
        holdCnt <= holdCnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stat.level     = level;
    stat.prevLevel = prevLevel;
    stat.rise      = level & ~prevLevel;
    stat.fall      = ~level & prevLevel;
    stat.quietDone = quietDone;
    stat.holdBusy  = (holdCnt != '0);
  end

endmodule

// File: rtl/oc_alarm_control.sv
module oc_alarm_control
  import oc_alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgThreshEn,
  input  logic [CNT_W-1:0] cfgThreshold,
  input  logic             irqClear,
  input  ocStatus_t        stat,
  input  logic [CNT_W-1:0] evtCnt,
  output ocStrobe_t        strobe,
  output logic             irqFlag,
  output logic             throttleReq
);

  logic [CNT_W:0] nextCount;
  logic           threshHit;
  logic           irqSet;

  // Threshold 0 is always met, so every event interrupts.
  assign nextCount = {1'b0, evtCnt} + 1'b1;
  assign threshHit = nextCount >= {1'b0, cfgThreshold};
  assign irqSet    = stat.rise && cfgThreshEn && threshHit;

  always_comb begin
    strobe.cntInc       = stat.rise;
    strobe.cntClear     = irqSet || (stat.quietDone && !stat.rise);
    strobe.quietRestart = stat.rise;
    strobe.holdLoad     = stat.fall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqFlag <= 1'b0;
    else if (irqSet)   irqFlag <= 1'b1;
    else if (irqClear) irqFlag <= 1'b0;
  end

  // prevLevel covers the cycle between the fall and the hold-timer load.
  assign throttleReq = stat.level | stat.prevLevel | stat.holdBusy;

endmodule

// File: rtl/oc_alarm_guard.sv
module oc_alarm_guard
  import oc_alarm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FILT_W = 24,
  parameter int HOLD_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alarmIn,
  input  logic              cfgActiveLow,
  input  logic              cfgThreshEn,
  input  logic [CNT_W-1:0]  cfgThreshold,
  input  logic [FILT_W-1:0] cfgFilterCycles,
  input  logic [HOLD_W-1:0] cfgHoldUs,
  input  logic [PRE_W-1:0]  cfgCyclesPerUs,
  input  logic              irqClear,
  output logic              irqFlag,
  output logic              throttleReq
);

  ocStatus_t        stat;
  ocStrobe_t        strobe;
  logic [CNT_W-1:0] evtCnt;

  oc_alarm_datapath #(
    .CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W), .PRE_W(PRE_W), .SYNC_STAGES(2)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .alarmIn        (alarmIn),
    .cfgActiveLow   (cfgActiveLow),
    .cfgFilterCycles(cfgFilterCycles),
    .cfgHoldUs      (cfgHoldUs),
    .cfgCyclesPerUs (cfgCyclesPerUs),
    .strobe         (strobe),
    .stat           (stat),
    .evtCnt         (evtCnt)
  );

  oc_alarm_control #(.CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgThreshEn (cfgThreshEn),
    .cfgThreshold(cfgThreshold),
    .irqClear    (irqClear),
    .stat        (stat),
    .evtCnt      (evtCnt),
    .strobe      (strobe),
    .irqFlag     (irqFlag),
    .throttleReq (throttleReq)
  );

endmodule

// File: rtl/oc_alarm_guard_sva.sv
module oc_alarm_guard_sva
  import oc_alarm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgThreshEn,
  input logic [HOLD_W-1:0] cfgHoldUs,
  input logic              irqClear,
  input logic              irqFlag,
  input logic              throttleReq,
  input logic [CNT_W-1:0]  evtCnt,
  input ocStatus_t         stat
);

  assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> evtCnt == '0);

  assert_no_irq_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgThreshEn && !irqFlag) |=> !irqFlag);

  assert_quiet_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stat.quietDone && !stat.rise) |=> evtCnt == '0);

  assert_hold_engaged_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stat.fall && cfgHoldUs != '0) |=> throttleReq);

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClear) |=> irqFlag);

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !stat.rise) |=> !irqFlag);

  always_comb begin
    if (rstN && irqFlag === 1'bx) begin
      assert_irq_known_R1: assert (1'b0);
    end
  end

endmodule

bind oc_alarm_guard oc_alarm_guard_sva #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .cfgThreshEn(cfgThreshEn),
  .cfgHoldUs  (cfgHoldUs),
  .irqClear   (irqClear),
  .irqFlag    (irqFlag),
  .throttleReq(throttleReq),
  .evtCnt     (evtCnt),
  .stat       (stat)
);

// File: tb/oc_alarm_guard_tb.sv
module oc_alarm_guard_tb;

  localparam int CNT_W  = 8;
  localparam int FILT_W = 24;
  localparam int HOLD_W = 16;
  localparam int PRE_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              alarmIn = 1'b0;
  logic              cfgActiveLow = 1'b0;
  logic              cfgThreshEn = 1'b1;
  logic [CNT_W-1:0]  cfgThreshold = '0;
  logic [FILT_W-1:0] cfgFilterCycles = '0;
  logic [HOLD_W-1:0] cfgHoldUs = '0;
  logic [PRE_W-1:0]  cfgCyclesPerUs = 8'd1;
  logic              irqClear = 1'b0;
  logic              irqFlag;
  logic              throttleReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oc_alarm_guard #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W), .PRE_W(PRE_W)) u_dut (
    .clk(clk), .rstN(rstN), .alarmIn(alarmIn), .cfgActiveLow(cfgActiveLow),
    .cfgThreshEn(cfgThreshEn), .cfgThreshold(cfgThreshold),
    .cfgFilterCycles(cfgFilterCycles), .cfgHoldUs(cfgHoldUs),
    .cfgCyclesPerUs(cfgCyclesPerUs), .irqClear(irqClear),
    .irqFlag(irqFlag), .throttleReq(throttleReq)
  );

  task automatic check(input bit actual, input bit expected, input string tag);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    alarmIn = cfgActiveLow;
    irqClear = 1'b0;
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
  endtask

  task automatic pulse(input int activeCyc, input int gapCyc);
    alarmIn = ~cfgActiveLow;
    waitCyc(activeCyc);
    alarmIn = cfgActiveLow;
    waitCyc(gapCyc);
  endtask

  task automatic clearIrq();
    irqClear = 1'b1;
    waitCyc(1);
    irqClear = 1'b0;
    waitCyc(1);
  endtask

  task automatic testReset();
    cfgActiveLow = 1'b0; cfgThreshEn = 1'b1; cfgThreshold = 8'd0;
    cfgFilterCycles = '0; cfgHoldUs = '0; cfgCyclesPerUs = 8'd1;
    doReset();
    check(irqFlag, 1'b0, "R1 irq after reset");
    check(throttleReq, 1'b0, "R1 throttle after reset");
  endtask

  task automatic testEveryEvent();
    cfgThreshold = 8'd0; cfgThreshEn = 1'b1;
    doReset();
    pulse(3, 6);
    check(irqFlag, 1'b1, "R4 first event interrupts");
    clearIrq();
    check(irqFlag, 1'b0, "R11 clear pulse");
    waitCyc(10);
    check(irqFlag, 1'b0, "R11 stays clear");
    pulse(3, 6);
    check(irqFlag, 1'b1, "R4 second event interrupts");
    waitCyc(20);
    check(irqFlag, 1'b1, "R11 sticky without clear");
  endtask

  task automatic testThreshold();
    cfgThreshold = 8'd3; cfgThreshEn = 1'b1; cfgFilterCycles = '0;
    doReset();
    pulse(3, 6); pulse(3, 6);
    check(irqFlag, 1'b0, "R3 two of three events");
    pulse(3, 6);
    check(irqFlag, 1'b1, "R3 third event");
    clearIrq();
    pulse(3, 6); pulse(3, 6);
    check(irqFlag, 1'b0, "R3 count restarted");
    pulse(3, 6);
    check(irqFlag, 1'b1, "R3 sixth event");
  endtask

  task automatic testDisabled();
    cfgThreshold = 8'd0; cfgThreshEn = 1'b0;
    doReset();
    for (int i = 0; i < 5; i++) pulse(3, 6);
    check(irqFlag, 1'b0, "R5 counting disabled");
    cfgThreshEn = 1'b1;
  endtask

  task automatic testFilter();
    cfgThreshEn = 1'b1; cfgThreshold = 8'd3; cfgFilterCycles = 24'd20;
    doReset();
    for (int i = 0; i < 3; i++) pulse(2, 8);
    check(irqFlag, 1'b1, "R6 close events accumulate");
    doReset();
    for (int i = 0; i < 3; i++) pulse(2, 58);
    check(irqFlag, 1'b0, "R6 quiet gap clears count");
    cfgFilterCycles = '0;
    doReset();
    for (int i = 0; i < 3; i++) pulse(2, 58);
    check(irqFlag, 1'b1, "R7 filter off keeps count");
  endtask

  task automatic testLongAlarm();
    cfgThreshEn = 1'b1; cfgThreshold = 8'd2; cfgFilterCycles = '0; cfgHoldUs = '0;
    doReset();
    pulse(50, 6);
    check(irqFlag, 1'b0, "R12 long alarm is one event");
    pulse(3, 6);
    check(irqFlag, 1'b1, "R12 second distinct event");
  endtask

  task automatic testPolarity();
    cfgActiveLow = 1'b1; cfgThreshEn = 1'b1; cfgThreshold = 8'd0; cfgHoldUs = '0;
    doReset();
    check(irqFlag, 1'b0, "R2 idle high is inactive");
    check(throttleReq, 1'b0, "R2 no throttle when high");
    alarmIn = 1'b0;
    waitCyc(4);
    check(throttleReq, 1'b1, "R2 low level throttles");
    alarmIn = 1'b1;
    waitCyc(6);
    check(irqFlag, 1'b1, "R2 low pulse interrupts");
    cfgActiveLow = 1'b0;
  endtask

  task automatic testHold();
    cfgActiveLow = 1'b0; cfgThreshEn = 1'b0; cfgHoldUs = 16'd3; cfgCyclesPerUs = 8'd4;
    doReset();
    alarmIn = 1'b1;
    waitCyc(3);
    check(throttleReq, 1'b1, "R8 throttle follows alarm");
    waitCyc(20);
    check(throttleReq, 1'b1, "R8 throttle while active");
    alarmIn = 1'b0;
    waitCyc(9);
    check(throttleReq, 1'b1, "R9 held mid window");
    waitCyc(16);
    check(throttleReq, 1'b0, "R9 released after window");
    cfgHoldUs = '0;
    alarmIn = 1'b1;
    waitCyc(10);
    alarmIn = 1'b0;
    waitCyc(4);
    check(throttleReq, 1'b0, "R10 zero hold releases");
    cfgThreshEn = 1'b1; cfgCyclesPerUs = 8'd1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testEveryEvent();
    testThreshold();
    testDisabled();
    testFilter();
    testLongAlarm();
    testPolarity();
    testHold();
    finishRun();
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule